// File: doc/BRIEF.md
# Overlapped Forward/Backward Timestep Job Scheduler

This block hands out work to a bank of identical compute lanes in a training engine for spiking networks. One start command carries the layer count and the timestep count of a training step. The scheduler then issues forward jobs and backward jobs, each tagged with a layer and a timestep, and waits for the lanes to report them finished. Every timestep owns a group of lanes. If there are fewer timesteps than lanes, the spare lanes join the groups, and each job is split into one slice per lane of its group.

Only spatial gradients are propagated, so the backward chains of different timesteps do not depend on each other. A timestep starts its backward chain as soon as its own last forward layer has finished. The forward work of later timesteps and the backward work of earlier ones therefore run side by side on different lanes. Forward layers still chain across timesteps, because membrane state carries from one timestep to the next. When every job has retired, the block raises a one-cycle done pulse and returns to idle.

Top module: `bts_sched`

## Requirements
- R1: While idle, a start pulse is accepted. The job count is L = `start_layers_m1`+1 and the timestep count is T = `start_steps_m1`+1. `busy` is high from the cycle after acceptance. The first job issued is a forward job for layer 0 of timestep 0.
- R2: The group size is G = floor(N_LANES/T). Lane i serves timestep i/G as slice i mod G when i < G*T. Every other lane never raises `iss_valid`.
- R3: Each job is issued exactly once on every lane of its timestep's group. The job retires only when all G slices have signalled completion. A full run issues 2*L*T*G lane handshakes.
- R4: Within one timestep, forward layers issue in ascending order. Layer l issues only after every slice of layer l-1 of that timestep has completed.
- R5: Forward layer l of timestep t+1 issues only after every slice of forward layer l of timestep t has completed.
- R6: The backward chain of a timestep starts at layer L-1, and only after that timestep's forward layer L-1 has completed. It then descends to layer 0, and each backward layer issues only after backward layer l+1 of the same timestep has completed.
- R7: Backward jobs of a timestep issue while forward jobs of later timesteps are still outstanding. Backward jobs of a later timestep issue before the backward chain of an earlier timestep has finished.
- R8: Once `iss_valid` is raised on a lane, it stays high until `iss_ready` is sampled high. All job fields on that lane stay unchanged while it waits.
- R9: `done` is high for exactly one cycle. It rises on the second rising edge after the edge that captures the final completion, and `busy` falls on that same edge.
- R10: A start pulse while busy is ignored. The running configuration and the job count are unchanged, and no extra done is produced.
- R11: During and right after reset, `busy`, `done` and all `iss_valid` are low. A reset in the middle of a run abandons that run, and the next start behaves normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Start pulse for a training step |
| start_layers_m1 | input | LW | Layer count minus one |
| start_steps_m1 | input | TW | Timestep count minus one |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse after all jobs retired |
| iss_valid | output | N_LANES | Per-lane job offer |
| iss_ready | input | N_LANES | Per-lane job acceptance |
| iss_bwd | output | N_LANES | Per-lane job kind: 1 backward, 0 forward |
| iss_layer | output | N_LANES*LW | Per-lane layer index, lane i at bits [i*LW +: LW] |
| iss_step | output | N_LANES*TW | Per-lane timestep index |
| iss_slice | output | N_LANES*TW | Per-lane slice index within the group |
| cpl | input | N_LANES | Per-lane completion pulse for the accepted job |

## Verification
The scheduler is run with several shapes that tell different behaviours apart:
- All lanes on distinct timesteps (T=8), which exercises cross-timestep forward chaining and overlap.
- A single timestep spread over eight slices, which exercises slice gathering.
- A non-dividing count (T=3), which leaves two lanes idle.
- A single-layer run, where the forward and backward ends coincide.

Lanes accept at once or with gaps, and completion latencies vary by lane. These lanes make a wrong dependency show up as an early issue rather than hide behind uniform timing. Directed cases cover a start while busy, the exact done cycle, and a reset in the middle of a run.

// File: rtl/bts_pkg.sv
package bts_pkg;

  typedef enum logic {
    JOB_FWD = 1'b0,
    JOB_BWD = 1'b1
  } job_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_FWAIT = 3'd1,
    ST_FRUN = 3'd2,
    ST_BRUN = 3'd3,
    ST_FIN = 3'd4
  } slot_state_e;

endpackage

// File: rtl/bts_lane_map.sv
module bts_lane_map #(
  parameter int N_LANES = 8,
  parameter int TW = 3
) (
  input  logic [TW-1:0]         steps_m1,
  output logic [N_LANES-1:0]    lane_used,
  output logic [N_LANES*TW-1:0] lane_step,
  output logic [N_LANES*TW-1:0] lane_slice
);

  int grp;
  int steps;

  always_comb begin
    steps = int'(steps_m1) + 1;
    grp = 1;
    for (int k = 1; k <= N_LANES; k++) begin
      if (k * steps <= N_LANES) grp = k;
    end
    lane_used = '0;
    lane_step = '0;
    lane_slice = '0;
    for (int i = 0; i < N_LANES; i++) begin
      lane_used[i] = (i < grp * steps);
      for (int t = 0; t < N_LANES; t++) begin
        if ((i >= t * grp) && (i < (t + 1) * grp)) begin
          lane_step[i*TW +: TW] = TW'(t);
          lane_slice[i*TW +: TW] = TW'(i - t * grp);
        end
      end
    end
  end

endmodule

// File: rtl/bts_lane_port.sv
module bts_lane_port #(
  parameter int LW = 4,
  parameter int TW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  logic          launch_bwd,
  input  logic [LW-1:0] launch_layer,
  input  logic [TW-1:0] launch_step,
  input  logic [TW-1:0] launch_slice,
  input  logic          ready,
  input  logic          cpl,
  output logic          valid,
  output logic          job_bwd,
  output logic [LW-1:0] job_layer,
  output logic [TW-1:0] job_step,
  output logic [TW-1:0] job_slice,
  output logic          idle
);

  logic pend_q, pend_d;
  logic busy_q, busy_d;
  logic hs;

  assign hs = pend_q && ready;

  always_comb begin
    pend_d = pend_q;
    busy_d = busy_q;
    if (hs) begin
      pend_d = 1'b0;
      busy_d = 1'b1;
    end
    if (cpl) busy_d = 1'b0;
    if (launch) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      busy_q <= busy_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      job_bwd <= 1'b0;
      job_layer <= '0;
      job_step <= '0;
      job_slice <= '0;
    end else if (launch) begin
      job_bwd <= launch_bwd;
      job_layer <= launch_layer;
      job_step <= launch_step;
      job_slice <= launch_slice;
    end
  end

  assign valid = pend_q;
  assign idle = !pend_q && !busy_q;

  // R3: a completion only arrives for an accepted, running job
  p_cpl_only_running_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cpl |-> busy_q);

  // R3: a new slice is never loaded over one still outstanding
  p_launch_when_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> (!pend_q && !busy_q));

  // R8: an offer is held with stable fields until taken
  p_offer_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(job_bwd) && $stable(job_layer)
                           && $stable(job_step) && $stable(job_slice)));

endmodule

// File: rtl/bts_step_ctrl.sv
module bts_step_ctrl
  import bts_pkg::*;
#(
  parameter int LW = 4,
  parameter bit FIRST = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          clr,
  input  logic          active,
  input  logic [LW-1:0] layers_m1,
  input  logic [LW:0]   prev_fdone,
  input  logic          job_idle,
  output logic          launch,
  output job_kind_e     launch_kind,
  output logic [LW-1:0] launch_layer,
  output logic [LW:0]   fdone,
  output logic          fin
);

  slot_state_e   state_q, state_d;
  logic [LW-1:0] lyr_q, lyr_d;
  logic [LW:0]   fdone_q, fdone_d;
  logic          dep_ok;

  assign dep_ok = FIRST || ({1'b0, lyr_q} < prev_fdone);

  always_comb begin
    state_d = state_q;
    lyr_d = lyr_q;
    fdone_d = fdone_q;
    launch = 1'b0;
    launch_kind = JOB_FWD;
    launch_layer = lyr_q;
    case (state_q)
      ST_IDLE: begin
        if (go) begin
          state_d = ST_FWAIT;
          lyr_d = '0;
          fdone_d = '0;
        end
      end
      ST_FWAIT: begin
        if (!active) begin
          state_d = ST_FIN;
        end else if (dep_ok) begin
          launch = 1'b1;
          state_d = ST_FRUN;
        end
      end
      ST_FRUN: begin
        if (job_idle) begin
          fdone_d = fdone_q + (LW+1)'(1);
          if (lyr_q == layers_m1) begin
            launch = 1'b1;
            launch_kind = JOB_BWD;
            state_d = ST_BRUN;
          end else begin
            lyr_d = lyr_q + LW'(1);
            state_d = ST_FWAIT;
          end
        end
      end
      ST_BRUN: begin
        if (job_idle) begin
          if (lyr_q == '0) begin
            state_d = ST_FIN;
          end else begin
            lyr_d = lyr_q - LW'(1);
            launch = 1'b1;
            launch_kind = JOB_BWD;
            launch_layer = lyr_q - LW'(1);
          end
        end
      end
      default: ;
    endcase
    if (clr) state_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      lyr_q <= '0;
      fdone_q <= '0;
    end else begin
      state_q <= state_d;
      lyr_q <= lyr_d;
      fdone_q <= fdone_d;
    end
  end

  assign fdone = fdone_q;
  assign fin = (state_q == ST_FIN);

  // R6: the backward chain runs only once all forward layers of this step retired
  p_bwd_after_all_fwd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BRUN) |-> (fdone_q == ({1'b0, layers_m1} + (LW+1)'(1))));

  // R4: forward progress never runs past the configured layer count
  p_fwd_bounded_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FRUN || state_q == ST_FWAIT) |-> (lyr_q <= layers_m1));

  generate
    if (!FIRST) begin : g_dep
      // R5: a timestep never has more forward layers retired than its predecessor
      p_fwd_behind_prev_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && active) |-> (fdone_q <= prev_fdone));
    end
  endgenerate

endmodule

// File: rtl/bts_sched.sv
module bts_sched
  import bts_pkg::*;
#(
  parameter int N_LANES = 8,
  parameter int MAX_LAYERS = 16
) (
  input  logic                                         clk,
  input  logic                                         rst_n,
  input  logic                                         start,
  input  logic [((MAX_LAYERS>1)?$clog2(MAX_LAYERS):1)-1:0] start_layers_m1,
  input  logic [((N_LANES>1)?$clog2(N_LANES):1)-1:0]       start_steps_m1,
  output logic                                         busy,
  output logic                                         done,
  output logic [N_LANES-1:0]                           iss_valid,
  input  logic [N_LANES-1:0]                           iss_ready,
  output logic [N_LANES-1:0]                           iss_bwd,
  output logic [N_LANES*((MAX_LAYERS>1)?$clog2(MAX_LAYERS):1)-1:0] iss_layer,
  output logic [N_LANES*((N_LANES>1)?$clog2(N_LANES):1)-1:0]       iss_step,
  output logic [N_LANES*((N_LANES>1)?$clog2(N_LANES):1)-1:0]       iss_slice,
  input  logic [N_LANES-1:0]                           cpl
);

  localparam int LW = (MAX_LAYERS > 1) ? $clog2(MAX_LAYERS) : 1;
  localparam int TW = (N_LANES > 1) ? $clog2(N_LANES) : 1;

  // reset: asserted asynchronously, released through two flops
  logic rst_s1, rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_sn <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_sn <= rst_s1;
    end
  end

  logic          run_q, run_d;
  logic          done_q;
  logic [LW-1:0] layers_q;
  logic [TW-1:0] steps_q;
  logic          go, clr, all_fin;

  logic [N_LANES-1:0]    lane_used;
  logic [N_LANES*TW-1:0] lane_step;
  logic [N_LANES*TW-1:0] lane_slice;
  logic [N_LANES-1:0]    lane_idle;
  logic [N_LANES-1:0]    lane_launch;
  logic [N_LANES-1:0]    lane_launch_bwd;
  logic [LW-1:0]         lane_launch_layer [N_LANES];

  logic [N_LANES-1:0]    slot_launch;
  job_kind_e             slot_kind [N_LANES];
  logic [LW-1:0]         slot_layer [N_LANES];
  logic [LW:0]           slot_fdone [N_LANES];
  logic [N_LANES-1:0]    slot_fin;
  logic [N_LANES-1:0]    slot_idle;

  assign go = start && !run_q;
  assign all_fin = &slot_fin;
  assign clr = run_q && all_fin;

  always_comb begin
    run_d = run_q;
    if (go) run_d = 1'b1;
    else if (clr) run_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      run_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      run_q <= run_d;
      done_q <= clr;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      layers_q <= '0;
      steps_q <= '0;
    end else if (go) begin
      layers_q <= start_layers_m1;
      steps_q <= start_steps_m1;
    end
  end

  assign busy = run_q;
  assign done = done_q;

  bts_lane_map #(.N_LANES(N_LANES), .TW(TW)) u_map (
    .steps_m1  (steps_q),
    .lane_used (lane_used),
    .lane_step (lane_step),
    .lane_slice(lane_slice)
  );

  // per-timestep controllers
  generate
    for (genvar s = 0; s < N_LANES; s++) begin : g_slot
      logic [LW:0] prev;
      logic        act;
      if (s == 0) begin : g_head
        assign prev = '0;
      end else begin : g_chain
        assign prev = slot_fdone[s-1];
      end
      assign act = ((TW+1)'(s) <= {1'b0, steps_q});

      bts_step_ctrl #(.LW(LW), .FIRST(s == 0)) u_slot (
        .clk         (clk),
        .rst_n       (rst_sn),
        .go          (go),
        .clr         (clr),
        .active      (act),
        .layers_m1   (layers_q),
        .prev_fdone  (prev),
        .job_idle    (slot_idle[s]),
        .launch      (slot_launch[s]),
        .launch_kind (slot_kind[s]),
        .launch_layer(slot_layer[s]),
        .fdone       (slot_fdone[s]),
        .fin         (slot_fin[s])
      );
    end
  endgenerate

  // gather lane state per timestep group
  always_comb begin
    slot_idle = '1;
    for (int s = 0; s < N_LANES; s++) begin
      for (int i = 0; i < N_LANES; i++) begin
        if (lane_used[i] && (lane_step[i*TW +: TW] == TW'(s)) && !lane_idle[i])
          slot_idle[s] = 1'b0;
      end
    end
  end

  // fan each timestep's launch out to its lanes
  always_comb begin
    for (int i = 0; i < N_LANES; i++) begin
      lane_launch[i] = lane_used[i] && slot_launch[lane_step[i*TW +: TW]];
      lane_launch_bwd[i] = (slot_kind[lane_step[i*TW +: TW]] == JOB_BWD);
      lane_launch_layer[i] = slot_layer[lane_step[i*TW +: TW]];
    end
  end

  generate
    for (genvar i = 0; i < N_LANES; i++) begin : g_lane
      bts_lane_port #(.LW(LW), .TW(TW)) u_lane (
        .clk         (clk),
        .rst_n       (rst_sn),
        .launch      (lane_launch[i]),
        .launch_bwd  (lane_launch_bwd[i]),
        .launch_layer(lane_launch_layer[i]),
        .launch_step (lane_step[i*TW +: TW]),
        .launch_slice(lane_slice[i*TW +: TW]),
        .ready       (iss_ready[i]),
        .cpl         (cpl[i]),
        .valid       (iss_valid[i]),
        .job_bwd     (iss_bwd[i]),
        .job_layer   (iss_layer[i*LW +: LW]),
        .job_step    (iss_step[i*TW +: TW]),
        .job_slice   (iss_slice[i*TW +: TW]),
        .idle        (lane_idle[i])
      );
    end
  endgenerate

  // R9: done is a single-cycle pulse
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    done |=> !done);

  // R9: done follows the end of a run
  p_done_ends_run_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    $fell(run_q) |-> done);

  // R10: configuration is frozen while a run is in progress
  p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (!rst_sn)
    (run_q && start) |=> ($stable(layers_q) && $stable(steps_q)));

  // R2: lanes outside the active groups never offer work
  p_unused_quiet_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    ((iss_valid & ~lane_used) == '0));

  // R11: nothing is offered outside a run
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_sn)
    !run_q |-> (iss_valid == '0));

endmodule

// File: tb/bts_sched_tb.sv
module bts_sched_tb;

  localparam int N = 8;
  localparam int LW = 4;
  localparam int TW = 3;
  localparam int NEVER = 32'h7fffffff;
  localparam int NV = 6;
  // columns: layers, timesteps, latency base, ready mode, inject start while busy
  localparam int VEC [NV][5] = '{
    '{3, 8, 2, 0, 0},
    '{1, 1, 1, 0, 0},
    '{16, 8, 1, 1, 1},
    '{4, 3, 3, 1, 0},
    '{2, 5, 1, 0, 1},
    '{16, 1, 2, 1, 0}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic start;
  logic [LW-1:0] start_layers_m1;
  logic [TW-1:0] start_steps_m1;
  logic busy, done;
  logic [N-1:0] iss_valid, iss_ready, iss_bwd, cpl;
  logic [N*LW-1:0] iss_layer;
  logic [N*TW-1:0] iss_step, iss_slice;

  always #4 clk = ~clk;

  bts_sched #(.N_LANES(N), .MAX_LAYERS(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .start_layers_m1(start_layers_m1), .start_steps_m1(start_steps_m1),
    .busy(busy), .done(done),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_bwd(iss_bwd),
    .iss_layer(iss_layer), .iss_step(iss_step), .iss_slice(iss_slice),
    .cpl(cpl)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  int comp_cyc [2][N][16];
  int slice_cnt [2][N][16];
  int lat_cnt [N];
  int job_k [N], job_t [N], job_l [N];
  logic hold_v [N];
  logic [LW+2*TW:0] hold_f [N];
  int issued, done_cnt, done_cyc, last_cpl, first_seen;
  int ovl_fb, ovl_bb;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int k = 0; k < 2; k++)
      for (int t = 0; t < N; t++)
        for (int l = 0; l < 16; l++) begin
          comp_cyc[k][t][l] = NEVER;
          slice_cnt[k][t][l] = 0;
        end
    for (int i = 0; i < N; i++) begin
      lat_cnt[i] = -1;
      hold_v[i] = 1'b0;
    end
    issued = 0; done_cnt = 0; done_cyc = -1; last_cpl = -1; first_seen = 0;
    ovl_fb = 0; ovl_bb = 0;
    cpl = '0;
    iss_ready = '0;
  endtask

  // one bench cycle: completions, offers, acceptance, all at the falling edge
  task automatic step(input int nl, input int nt, input int g, input int latb, input int rmode);
    @(negedge clk);
    cyc++;
    if (done) begin
      done_cnt++;
      done_cyc = cyc;
    end
    for (int i = 0; i < N; i++) begin
      cpl[i] = 1'b0;
      if (lat_cnt[i] > 0) begin
        lat_cnt[i]--;
        if (lat_cnt[i] == 0) begin
          lat_cnt[i] = -1;
          cpl[i] = 1'b1;
          slice_cnt[job_k[i]][job_t[i]][job_l[i]]++;
          if (slice_cnt[job_k[i]][job_t[i]][job_l[i]] == g) begin
            comp_cyc[job_k[i]][job_t[i]][job_l[i]] = cyc;
            last_cpl = cyc;
          end
        end
      end
    end
    for (int i = 0; i < N; i++) begin
      logic [LW+2*TW:0] f;
      f = {iss_bwd[i], iss_layer[i*LW +: LW], iss_step[i*TW +: TW], iss_slice[i*TW +: TW]};
      if (hold_v[i]) begin
        check(iss_valid[i] && (f == hold_f[i]), "R8", "offer held stable", int'(f), int'(hold_f[i]));
        hold_v[i] = 1'b0;
      end
      iss_ready[i] = (rmode == 0) ? 1'b1 : (((cyc + i) % 3) != 0);
      if (iss_valid[i] && !iss_ready[i]) begin
        hold_v[i] = 1'b1;
        hold_f[i] = f;
      end
      if (iss_valid[i] && iss_ready[i]) begin
        int k, t, l, sl;
        k = int'(iss_bwd[i]); t = int'(iss_step[i*TW +: TW]);
        l = int'(iss_layer[i*LW +: LW]); sl = int'(iss_slice[i*TW +: TW]);
        if (!first_seen) begin
          first_seen = 1;
          check(k == 0 && t == 0 && l == 0, "R1", "first job fwd/t0/l0", k*1000 + t*100 + l, 0);
        end
        check(i < g * nt, "R2", "lane in active groups", i, g * nt - 1);
        check(t == i / g && sl == i % g, "R2", "lane maps to step/slice", t*100 + sl, (i/g)*100 + (i%g));
        if (t < nt && l < nl) begin
          if (k == 0) begin
            if (l > 0) check(comp_cyc[0][t][l-1] < cyc, "R4", "fwd after prior layer", comp_cyc[0][t][l-1], cyc);
            if (t > 0) check(comp_cyc[0][t-1][l] < cyc, "R5", "fwd after prior step", comp_cyc[0][t-1][l], cyc);
          end else begin
            if (l == nl - 1) check(comp_cyc[0][t][nl-1] < cyc, "R6", "bwd after last fwd", comp_cyc[0][t][nl-1], cyc);
            else check(comp_cyc[1][t][l+1] < cyc, "R6", "bwd descending", comp_cyc[1][t][l+1], cyc);
            for (int t2 = t + 1; t2 < nt; t2++)
              if (comp_cyc[0][t2][nl-1] == NEVER) ovl_fb = 1;
            for (int t2 = 0; t2 < t; t2++)
              if (comp_cyc[1][t2][0] == NEVER) ovl_bb = 1;
          end
        end else begin
          check(1'b0, "R3", "job index in range", t*100 + l, 0);
        end
        job_k[i] = k; job_t[i] = t; job_l[i] = l;
        lat_cnt[i] = latb + ((i + issued) % 3);
        issued++;
        hold_v[i] = 1'b0;
      end
    end
  endtask

  task automatic run_cfg(input int nl, input int nt, input int latb, input int rmode, input int inj);
    int g, t0, guard;
    g = N / nt;
    clear_model();
    @(negedge clk);
    cyc++;
    start = 1'b1;
    start_layers_m1 = LW'(nl - 1);
    start_steps_m1 = TW'(nt - 1);
    @(negedge clk);
    cyc++;
    start = 1'b0;
    check(busy == 1'b1, "R1", "busy after start", int'(busy), 1);
    t0 = cyc;
    guard = 0;
    while (done_cnt == 0 && guard < 20000) begin
      if (inj != 0 && cyc == t0 + 10) begin
        start = 1'b1;
        start_layers_m1 = 4'd0;
        start_steps_m1 = 3'd0;
      end else begin
        start = 1'b0;
      end
      step(nl, nt, g, latb, rmode);
      if (inj != 0 && cyc == t0 + 12)
        check(busy == 1'b1, "R10", "start while busy ignored", int'(busy), 1);
      guard++;
    end
    start = 1'b0;
    if (guard >= 20000) check(1'b0, "R9", "watchdog: run never finished", guard, 0);
    check(done_cyc == last_cpl + 3, "R9", "done cycle", done_cyc, last_cpl + 3);
    check(busy == 1'b0, "R9", "busy falls with done", int'(busy), 0);
    for (int j = 0; j < 3; j++) step(nl, nt, g, latb, rmode);
    check(done_cnt == 1, "R9", "single done pulse", done_cnt, 1);
    check(issued == 2 * nl * nt * g, "R3", "handshake total", issued, 2 * nl * nt * g);
    if (inj != 0) check(issued == 2 * nl * nt * g, "R10", "ignored start kept config", issued, 2 * nl * nt * g);
    if (nt >= 2 && nl >= 2) begin
      check(ovl_fb == 1, "R7", "bwd overlaps later fwd", ovl_fb, 1);
      check(ovl_bb == 1, "R7", "bwd chains overlap", ovl_bb, 1);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    start_layers_m1 = '0;
    start_steps_m1 = '0;
    clear_model();
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0 && iss_valid == '0, "R11", "quiet in reset", int'(iss_valid), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(busy == 0 && done == 0 && iss_valid == '0, "R11", "quiet after reset", int'(iss_valid), 0);

    for (int v = 0; v < NV; v++)
      run_cfg(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4]);

    // reset in the middle of a run, then recover
    clear_model();
    @(negedge clk);
    start = 1'b1;
    start_layers_m1 = 4'd7;
    start_steps_m1 = 3'd7;
    @(negedge clk);
    start = 1'b0;
    repeat (15) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(busy == 0 && iss_valid == '0, "R11", "mid-run reset quiets", int'(iss_valid), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(busy == 0 && done == 0, "R11", "idle after mid-run reset", int'(busy), 0);
    run_cfg(2, 4, 1, 0, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule